// File: doc/BRIEF.md
# Write Protection Gate

This block stands in the write path of a nonvolatile memory's command interface. It turns the raw chip enable, output enable and write enable lines into a qualified write strobe for the command decoder. All inputs are sampled on the system clock. The supply-good line is the digital output of an external comparator, and the gate treats it as a plain input.

Three protections act on the same strobe path:

- **Supply-sense inhibit.** While the supply is reported bad, no write is accepted.
- **Power-on hold-off.** After the supply becomes good, writes stay blocked for a fixed number of cycles. If the supply drops during that window, the count starts again from zero.
- **Glitch filter.** A write low phase must last a minimum number of samples before it counts as a write.

A valid low phase requires chip enable low, write enable low and output enable high, with the supply good and the hold-off expired. When such a phase ends, the gate emits a single-cycle pulse. The address captured at the start of the phase and the data captured at its end are presented with that pulse.

Top module: `wr_guard`

## Requirements
- R1: While `supply_ok` is low, no `wr_pulse` is issued. A low phase during which `supply_ok` drops produces no pulse.
- R2: After reset release with `supply_ok` high, a low phase is ignored until `supply_ok` has been sampled high on `HOLD_CYC` consecutive edges.
- R3: A drop of `supply_ok` during the hold-off restarts the count from zero. A write attempted fewer than `HOLD_CYC` cycles after the supply returns is ignored.
- R4: A write is only counted in samples where `ce_n`=0, `we_n`=0 and `oe_n`=1. Phases with `oe_n` low, or with `ce_n` high while `we_n` is low, give no pulse. `oe_n` going low inside a phase cancels that phase.
- R5: A low phase shorter than `MIN_W` samples gives no pulse. A phase of exactly `MIN_W` samples, or longer, gives one pulse.
- R6: `wr_pulse` is high for exactly one cycle. It is registered on the first edge that samples `we_n` or `ce_n` high (with `oe_n` high) after a qualifying phase, so it is visible in the cycle after that edge.
- R7: A phase may be ended by raising either `we_n` or `ce_n`. Both orders produce the same pulse.
- R8: While `rst_n` is low, `wr_pulse`, `wr_addr` and `wr_data` are 0 and any phase in progress is abandoned. After release the hold-off is timed again.
- R9: `wr_addr` carries the address of the first low sample of the accepted phase, and `wr_data` the data of its last low sample. Both hold their values until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, aborts activity |
| supply_ok | input | 1 | Supply-good flag from comparator |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_in | input | AW | Address bus |
| data_in | input | DW | Data bus |
| wr_pulse | output | 1 | Qualified single-cycle write strobe |
| wr_addr | output | AW | Address of the accepted write |
| wr_data | output | DW | Data of the accepted write |

## Verification
**Glitch filter and enable order.** Low phases of one, two, exactly `MIN_W` and longer samples are driven, ended by raising either write enable or chip enable. This separates the filter threshold from the choice of terminating line. The address and data are changed inside each phase, which shows that the address comes from the first low sample and the data from the last.

**Inhibits and hold-off.** Phases with output enable low, with write enable alone low, and phases cut by a supply drop or by reset show that each inhibit acts on its own. Writes attempted shortly after the supply returns, including after an interrupted hold-off, tell a restarted count apart from one that merely resumes.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  // bits needed to hold the value maxv
  function automatic int cnt_bits(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // one sample of a legal write low phase
  function automatic logic phase_valid(input logic ce_n, input logic oe_n, input logic we_n);
    return ~ce_n & ~we_n & oe_n;
  endfunction

  // a strobe line has risen while output enable stays high
  function automatic logic strobe_end(input logic ce_n, input logic oe_n, input logic we_n);
    return (ce_n | we_n) & oe_n;
  endfunction

endpackage

// File: rtl/wpg_holdoff.sv
module wpg_holdoff #(
  parameter int HOLD_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic hold_done
);
  localparam int CW = wpg_pkg::cnt_bits(HOLD_CYC);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!supply_ok)      cnt_q <= '0;
    else if (cnt_q != HOLD_V) cnt_q <= cnt_q + 1'b1;
  end

  assign hold_done = (cnt_q == HOLD_V);
endmodule

// File: rtl/wpg_width_filter.sv
module wpg_width_filter #(
  parameter int MIN_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_ok,
  input  logic end_ok,
  output logic first_low,
  output logic phase_end
);
  localparam int RW = wpg_pkg::cnt_bits(MIN_W);
  localparam logic [RW-1:0] MIN_V = RW'(MIN_W);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!low_ok)        run_q <= '0;
    else if (run_q != MIN_V) run_q <= run_q + 1'b1;
  end

  assign first_low = low_ok & (run_q == '0);
  assign phase_end = end_ok & (run_q == MIN_V);
endmodule

// File: rtl/wpg_capture.sv
module wpg_capture #(
  parameter int AW = 18,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_low,
  input  logic          low_ok,
  input  logic          fire,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '0;
    end else begin
      if (first_low) lat_addr <= addr_in;
      if (low_ok)    lat_data <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= fire;
      if (fire) begin
        wr_addr <= lat_addr;
        wr_data <= lat_data;
      end
    end
  end
endmodule

// File: rtl/wr_guard.sv
module wr_guard #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int HOLD_CYC = 2_000_000,
  parameter int MIN_W    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic hold_done;
  logic low_ok;
  logic end_ok;
  logic first_low;
  logic phase_end;
  logic gate_open;

  wpg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hold_done(hold_done)
  );

  assign gate_open = hold_done & supply_ok;
  assign low_ok    = gate_open & wpg_pkg::phase_valid(ce_n, oe_n, we_n);
  assign end_ok    = gate_open & wpg_pkg::strobe_end(ce_n, oe_n, we_n);

  wpg_width_filter #(.MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .low_ok(low_ok), .end_ok(end_ok),
    .first_low(first_low), .phase_end(phase_end)
  );

  wpg_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .first_low(first_low), .low_ok(low_ok),
    .fire(phase_end), .addr_in(addr_in), .data_in(data_in),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int HOLD_CYC = 2_000_000,
  parameter int MIN_W    = 3
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic wr_pulse,
  input logic hold_done,
  input logic low_ok
);
  int sup_run;
  int low_run;

  // independent count of consecutive good-supply samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sup_run <= 0;
    else if (!supply_ok)           sup_run <= 0;
    else if (sup_run < HOLD_CYC)   sup_run <= sup_run + 1;
  end

  // independent count of consecutive legal low samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!(supply_ok && hold_done && !ce_n && !we_n && oe_n)) low_run <= 0;
    else if (low_run < MIN_W) low_run <= low_run + 1;
  end

  p_supply_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wr_pulse);

  p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |-> (sup_run >= HOLD_CYC));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !hold_done);

  p_oe_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(oe_n));

  p_low_needs_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
    low_ok |-> (!ce_n && !we_n && oe_n));

  p_min_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> ($past(low_run) == MIN_W));

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r8: assert (!wr_pulse);
    end
  end
endmodule

bind wr_guard wpg_checker #(.HOLD_CYC(HOLD_CYC), .MIN_W(MIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .wr_pulse(wr_pulse), .hold_done(hold_done), .low_ok(low_ok)
);

// File: tb/wr_guard_bench.sv
module wr_guard_bench;
  localparam int AW   = 18;
  localparam int DW   = 16;
  localparam int HOLD = 40;
  localparam int MINW = 3;

  // entry: [11:4] low samples, [2] end by ce_n, [1] oe_n held low, [0] pulse expected
  localparam logic [11:0] VEC [10] = '{
    12'h031, 12'h020, 12'h010, 12'h051, 12'h035,
    12'h024, 12'h062, 12'h045, 12'h014, 12'h091
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_ok;
  logic          ce_n, oe_n, we_n;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] data_in;
  logic          wr_pulse;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done   = 1'b0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;

  always #2.5 clk = ~clk;

  wr_guard #(.AW(AW), .DW(DW), .HOLD_CYC(HOLD), .MIN_W(MINW)) u_wr_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr_in(addr_in), .data_in(data_in),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) if (wr_pulse) pulses++;

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_write(int n, bit by_ce, bit oe_low, logic [AW-1:0] a,
                          logic [DW-1:0] d, bit exp, string req);
    addr_in = a;
    data_in = ~d;
    if (by_ce) we_n = 1'b0; else ce_n = 1'b0;
    idle(1);
    oe_n = !oe_low;
    for (int i = 0; i < n; i++) begin
      if (by_ce) ce_n = 1'b0; else we_n = 1'b0;
      addr_in = (i == 0) ? a : ~a;
      data_in = (i == n - 1) ? d : ~d;
      idle(1);
    end
    if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
    oe_n = 1'b1;
    @(negedge clk);
    check_eq("R6", "pulse before end edge", {31'd0, wr_pulse}, 32'd0);
    @(negedge clk);
    check_eq(req, "pulse after end edge", {31'd0, wr_pulse}, {31'd0, exp});
    if (exp) begin
      check_eq("R9", "captured address", {14'd0, wr_addr}, {14'd0, a});
      check_eq("R9", "captured data", {16'd0, wr_data}, {16'd0, d});
      last_a = a;
      last_d = d;
    end
    @(negedge clk);
    check_eq("R6", "pulse width", {31'd0, wr_pulse}, 32'd0);
    idle(1);
    ce_n = 1'b1;
    we_n = 1'b1;
    idle(1);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; supply_ok = 1'b1;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr_in = '0; data_in = '0;
    idle(5);
    check_eq("R8", "pulse in reset", {31'd0, wr_pulse}, 32'd0);
    check_eq("R8", "address in reset", {14'd0, wr_addr}, 32'd0);
    check_eq("R8", "data in reset", {16'd0, wr_data}, 32'd0);
    rst_n = 1'b1;

    // R2: hold-off after reset release
    idle(3);
    do_write(3, 1'b0, 1'b0, 18'h00111, 16'h1234, 1'b0, "R2");
    idle(40);
    do_write(3, 1'b0, 1'b0, 18'h00222, 16'h2345, 1'b1, "R2");

    // R3: interrupted hold-off restarts from zero
    supply_ok = 1'b0; idle(2);
    supply_ok = 1'b1; idle(25);
    supply_ok = 1'b0; idle(2);
    supply_ok = 1'b1; idle(25);
    do_write(3, 1'b0, 1'b0, 18'h00333, 16'h3456, 1'b0, "R3");
    idle(20);
    do_write(3, 1'b0, 1'b0, 18'h00444, 16'h4567, 1'b1, "R3");

    // table: widths, end order, output enable
    for (int i = 0; i < 10; i++) begin
      logic [11:0] v;
      string req;
      v = VEC[i];
      req = v[1] ? "R4" : (v[2] ? "R7" : "R5");
      do_write(int'(v[11:4]), v[2], v[1], 18'h00155 + 18'(i * 'h101),
               16'hA5C3 ^ 16'(i * 'h1111), v[0], req);
      if (!v[0]) begin
        check_eq("R9", "address held", {14'd0, wr_addr}, {14'd0, last_a});
        check_eq("R9", "data held", {16'd0, wr_data}, {16'd0, last_d});
      end
    end

    // R4: write enable low with chip enable high
    p0 = pulses;
    we_n = 1'b0; idle(5);
    we_n = 1'b1; idle(4);
    check_eq("R4", "we alone", pulses - p0, 0);

    // R4: output enable falls inside a phase
    p0 = pulses;
    ce_n = 1'b0; we_n = 1'b0; idle(4);
    oe_n = 1'b0; idle(2);
    we_n = 1'b1; idle(3);
    oe_n = 1'b1; ce_n = 1'b1; idle(3);
    check_eq("R4", "oe cancel", pulses - p0, 0);

    // R1: supply drops during a phase
    p0 = pulses;
    ce_n = 1'b0; we_n = 1'b0; idle(4);
    supply_ok = 1'b0; idle(1);
    we_n = 1'b1; idle(3);
    ce_n = 1'b1; idle(1);
    check_eq("R1", "drop mid phase", pulses - p0, 0);
    do_write(4, 1'b0, 1'b0, 18'h00555, 16'h5678, 1'b0, "R1");
    supply_ok = 1'b1;
    idle(45);
    do_write(4, 1'b0, 1'b0, 18'h00666, 16'h6789, 1'b1, "R1");

    // R8: reset aborts a phase and retimes the hold-off
    p0 = pulses;
    ce_n = 1'b0; we_n = 1'b0; idle(4);
    rst_n = 1'b0; idle(1);
    check_eq("R8", "pulse in mid reset", {31'd0, wr_pulse}, 32'd0);
    we_n = 1'b1; idle(1);
    rst_n = 1'b1; idle(3);
    ce_n = 1'b1;
    check_eq("R8", "aborted phase", pulses - p0, 0);
    check_eq("R8", "address cleared", {14'd0, wr_addr}, 32'd0);
    do_write(3, 1'b0, 1'b0, 18'h00777, 16'h789A, 1'b0, "R8");
    idle(45);
    do_write(3, 1'b1, 1'b0, 18'h00888, 16'h89AB, 1'b1, "R8");

    done = 1'b1;
    finish_sim();
  end
endmodule